// File: doc/BRIEF.md
# Up/Down HH:MM:SS Elapsed-Time Counter

This block keeps an elapsed time as six binary-coded-decimal digits: two for hours, two for minutes and two for seconds. On every rising clock edge it can move the time forward or back by one second, as its two single-bit step requests direct. With no request it holds. The hours field runs from 00 to 99, so the block counts elapsed time and is not a time-of-day clock.

The counter is a cascade of six decimal digit cells. Each cell steps only when every less significant cell is at its turning point: the top of its range when counting up, zero when counting down. Carries and borrows therefore ripple through seconds, minutes and hours in a single edge. The six digit outputs feed a display decoder elsewhere. Segment decoding and display scanning belong to other blocks.

Top module: `tape_counter`

## Requirements
- R1: A low level on `rst_n`, sampled at a rising edge, sets all six digits to 0 at that edge. This takes precedence over `inc` and `dec`.
- R2: With `inc` high at a rising edge, the time becomes one second later at that edge.
- R3: With `dec` high and `inc` low at a rising edge, the time becomes one second earlier at that edge.
- R4: With both `inc` and `dec` low, every digit keeps its value across the edge.
- R5: With both `inc` and `dec` high, the counter steps up exactly as for `inc` alone.
- R6: Seconds-ones and minutes-ones wrap 9 to 0 when counting up and 0 to 9 when counting down, carrying into or borrowing from their tens digit. Seconds-tens and minutes-tens wrap 5 to 0 and 0 to 5 in the same way. Hours digits both wrap 9 to 0 and 0 to 9.
- R7: The carry and the borrow cross all fields in one step: 09:59:59 plus one second gives 10:00:00, and 10:00:00 minus one second gives 09:59:59.
- R8: The count wraps at the ends of its range: 99:59:59 plus one second gives 00:00:00, and 00:00:00 minus one second gives 99:59:59. The full span is 0 to 359999 seconds.
- R9: Every output digit is a valid digit for its position at all times out of reset. The tens digits of seconds and minutes are at most 5, and every other digit is at most 9. Each digit is a 4-bit BCD value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc | input | 1 | Step forward one second, active high |
| dec | input | 1 | Step back one second, active high |
| hr_tens | output | 4 | Hours, tens digit (0-9) |
| hr_ones | output | 4 | Hours, ones digit (0-9) |
| min_tens | output | 4 | Minutes, tens digit (0-5) |
| min_ones | output | 4 | Minutes, ones digit (0-9) |
| sec_tens | output | 4 | Seconds, tens digit (0-5) |
| sec_ones | output | 4 | Seconds, ones digit (0-9) |

## Verification
The assertions assume that `inc` and `dec` are synchronous to `clk` and hold stable values at each rising edge. They also assume that the count only ever comes from reset or from earlier steps, so the digits are never loaded with an out-of-range value. The stimulus changes the inputs only on falling edges, which keeps them settled at every sampling edge. It builds every state it checks by stepping from reset, including a continuous forward sweep from 00:00:00 through 10:00:00 and a wrap below zero. No other way of reaching those states is used.

// File: rtl/tape_ctr_pkg.sv
// Package: shared widths, digit positions and step encoding for the
// elapsed-time counter. Assumes digit 0 is seconds-ones and digit 5 is
// hours-tens.
package tape_ctr_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 6;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Largest value of the digit at position idx (tens of seconds/minutes = 5)
    function automatic int digit_limit(input int idx);
        if (idx == 1 || idx == 3) return 5;
        return 9;
    endfunction

endpackage

// File: rtl/tape_step_decode.sv
// Module: tape_step_decode
// Turns the two raw step requests into one step command. Forward wins when
// both are asserted. Assumes inputs are synchronous to the counter clock.
module tape_step_decode
    import tape_ctr_pkg::*;
(
    input  logic  inc,
    input  logic  dec,
    output step_e step
);

    // Priority decode of the step requests
    always_comb begin
        if (inc)      step = STEP_UP;
        else if (dec) step = STEP_DOWN;
        else          step = STEP_HOLD;
    end

endmodule

// File: rtl/tape_digit.sv
// Module: tape_digit
// One decimal digit cell that counts modulo LIMIT+1 in either direction.
// It steps only when en is high. at_edge tells the next cell that this one
// will wrap on a step in the current direction. Assumes the value never
// leaves 0..LIMIT, which holds from reset.
module tape_digit #(
    parameter int W     = 4,
    parameter int LIMIT = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         up,
    output logic [W-1:0] value,
    output logic         at_edge
);

    localparam logic [W-1:0] TOP = W'(LIMIT);
    localparam logic [W-1:0] ONE = W'(1);

    // Turning point for the current direction
    always_comb begin
        at_edge = up ? (value == TOP) : (value == '0);
    end

    // Digit register with wrap in both directions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (en) begin
            if (up) value <= at_edge ? '0  : value + ONE;
            else    value <= at_edge ? TOP : value - ONE;
        end
    end

endmodule

// File: rtl/tape_counter.sv
// Module: tape_counter (top)
// Up/down elapsed-time counter, HH:MM:SS in BCD, range 00:00:00 to
// 99:59:59 with wrap at both ends. Synchronous active-low reset clears
// all digits. Assumes inc/dec are synchronous to clk.
module tape_counter
    import tape_ctr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [3:0]   hr_tens,
    output logic [3:0]   hr_ones,
    output logic [3:0]   min_tens,
    output logic [3:0]   min_ones,
    output logic [3:0]   sec_tens,
    output logic [3:0]   sec_ones
);

    step_e                  step;
    logic                   going_up;
    logic [NUM_DIGITS:0]    en_chain;
    logic [NUM_DIGITS-1:0]  edge_vec;
    digit_t                 digits [NUM_DIGITS];

    tape_step_decode u_decode (
        .inc  (inc),
        .dec  (dec),
        .step (step)
    );

    // Direction and first enable of the ripple chain
    always_comb begin
        going_up    = (step == STEP_UP);
        en_chain[0] = (step != STEP_HOLD);
    end

    // Cascade of digit cells, least significant first
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        tape_digit #(
            .W     (DIGIT_W),
            .LIMIT (digit_limit(g))
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_chain[g]),
            .up      (going_up),
            .value   (digits[g]),
            .at_edge (edge_vec[g])
        );
        assign en_chain[g+1] = en_chain[g] & edge_vec[g];
    end

    // Map digit positions onto named outputs
    always_comb begin
        sec_ones = digits[0];
        sec_tens = digits[1];
        min_ones = digits[2];
        min_tens = digits[3];
        hr_ones  = digits[4];
        hr_tens  = digits[5];
    end

endmodule

// File: rtl/tape_counter_chk.sv
// Module: tape_counter_chk
// Property checker for tape_counter, attached by bind. Looks only at ports.
module tape_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inc,
    input logic       dec,
    input logic [3:0] hr_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] min_tens,
    input logic [3:0] min_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_ones
);

    logic [23:0] t;
    assign t = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (t == 24'h000000));

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && sec_ones != 4'd9) |=> (sec_ones == $past(sec_ones) + 4'd1));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && sec_ones != 4'd0) |=> (sec_ones == $past(sec_ones) - 4'd1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(t));

    p_both_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec && sec_ones != 4'd9) |=> (sec_ones == $past(sec_ones) + 4'd1));

    p_sec_tens_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && t[7:0] == 8'h59) |=> (t[7:0] == 8'h00));

    p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && t == 24'h095959) |=> (t == 24'h100000));

    p_borrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && t == 24'h100000) |=> (t == 24'h095959));

    p_wrap_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && t == 24'h995959) |=> (t == 24'h000000));

    p_wrap_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && t == 24'h000000) |=> (t == 24'h995959));

    p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ones <= 4'd9 && sec_tens <= 4'd5 && min_ones <= 4'd9 &&
         min_tens <= 4'd5 && hr_ones <= 4'd9 && hr_tens <= 4'd9));

endmodule

bind tape_counter tape_counter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .dec      (dec),
    .hr_tens  (hr_tens),
    .hr_ones  (hr_ones),
    .min_tens (min_tens),
    .min_ones (min_ones),
    .sec_tens (sec_tens),
    .sec_ones (sec_ones)
);

// File: tb/tape_counter_tb.sv
// Bench for tape_counter: a vector table walked by one loop, then directed
// tests for reset, full carry/borrow and wrap at both ends.
module tape_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;
    localparam int SPAN       = 360000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inc = 1'b0;
    logic       dec = 1'b0;
    logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;

    int n_tests = 0;
    int n_fail  = 0;

    // Vector table: {inc,dec} and expected seconds total after the edge
    localparam logic [1:0] VEC_CTL [NVEC] = '{
        2'b10, 2'b10, 2'b00, 2'b01, 2'b11, 2'b01,
        2'b01, 2'b01, 2'b00, 2'b10, 2'b11, 2'b01 };
    localparam int VEC_EXP [NVEC] = '{
        1, 2, 2, 1, 2, 1,
        0, 359999, 359999, 0, 1, 0 };
    localparam string VEC_TAG [NVEC] = '{
        "R2", "R2", "R4", "R3", "R5", "R3",
        "R3", "R8", "R4", "R8", "R5", "R3" };

    tape_counter u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .dec      (dec),
        .hr_tens  (hr_tens),
        .hr_ones  (hr_ones),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .sec_tens (sec_tens),
        .sec_ones (sec_ones)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] to_bcd(input int total);
        int h, m, s;
        h = total / 3600;
        m = (total % 3600) / 60;
        s = total % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10),
                4'(s / 10), 4'(s % 10)};
    endfunction

    function automatic logic [23:0] shown();
        return {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
    endfunction

    task automatic check(input string tag, input logic [23:0] exp);
        n_tests++;
        if (shown() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %06h expected %06h", tag, shown(), exp);
        end
    endtask

    // Apply one edge with the given requests; inputs set on a falling edge
    task automatic step(input logic i, input logic d);
        inc = i;
        dec = d;
        @(negedge clk);
        inc = 1'b0;
        dec = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", 24'h000000);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            step(VEC_CTL[v][1], VEC_CTL[v][0]);
            check(VEC_TAG[v], to_bcd(VEC_EXP[v]));
        end

        // R1: reset overrides a pending increment
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        rst_n = 1'b0;
        inc   = 1'b1;
        @(negedge clk);
        inc   = 1'b0;
        rst_n = 1'b1;
        check("R1 reset beats inc", 24'h000000);

        // R6/R2: forward sweep from 0 to 10:00:00, every step compared
        for (int k = 1; k <= 36000; k++) begin
            step(1'b1, 1'b0);
            check("R6 sweep", to_bcd(k));
        end
        check("R7 carry to 10:00:00", 24'h100000);

        // R7: borrow across all fields
        step(1'b0, 1'b1);
        check("R7 borrow to 09:59:59", 24'h095959);

        // R6: down-count through a minute boundary
        for (int k = 35998; k >= 35900; k--) begin
            step(1'b0, 1'b1);
            check("R6 down sweep", to_bcd(k));
        end

        // R4: hold for several cycles
        repeat (5) step(1'b0, 1'b0);
        check("R4 hold", to_bcd(35900));

        // R8: wrap at both ends
        do_reset();
        step(1'b0, 1'b1);
        check("R8 below zero", 24'h995959);
        step(1'b1, 1'b1);
        check("R8 above top with both", 24'h000000);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule